// File: doc/BRIEF.md
# UART Control and Channel-Mode Router

This block owns the control word of a serial port and decides where each byte goes. A byte can come from the host data register, from the line receiver or from a received break. It can go to the receive FIFO, to the transmit FIFO or nowhere. The choice depends on a 2-bit channel mode and on the enable and disable pairs in the control word. Both FIFOs are inside the block and their depths are parameters. The bit-level serializer sits outside. It sees the head of the transmit FIFO and pops it with a strobe. The line receiver offers one byte per cycle under a ready handshake.

Writing the control word can clear either FIFO. The two clear bits never stay set in the stored word. The word also carries a break request. A stop-break bit overrides the start-break bit. When a byte cannot be stored because its FIFO is full, the block drops it and raises a one-cycle event instead.

Top module: `uart_route_top`

## Requirements
- R1: Writing the control word with bit 0 set empties the RX FIFO, and with bit 1 set empties the TX FIFO. The level reads 0 two clock edges after the write edge. Bits 1:0 always read back as 0.
- R2: The RX path is on only while bit 2 is 1 and bit 3 is 0. The TX path is on only while bit 4 is 1 and bit 5 is 0. A disable bit wins over its enable bit. A byte routed to a path that is off is dropped.
- R3: `break_req` is 1 exactly when stored bit 7 is 1 and stored bit 8 is 0.
- R4: After reset the control word reads 0x128, both FIFOs are empty, `break_req` is 0 and `line_ready` is 1.
- R5: Line bytes are routed by mode as follows. Mode 0 (normal) sends them to the RX FIFO. Mode 1 (echo) sends them to both FIFOs. Mode 2 (local loopback) drops them. Mode 3 (remote loopback) sends them to the TX FIFO.
- R6: Host data writes are routed by mode as follows. Mode 0 sends them to the TX FIFO. Mode 2 sends them to the RX FIFO. Modes 1 and 3 drop them.
- R7: A byte sent to a full RX FIFO is dropped and pulses `rx_overrun_evt` for one cycle, one edge later. A byte sent to a full TX FIFO is dropped and pulses `tx_overflow_evt` the same way. The FIFO level stays at its depth.
- R8: A host read returns the oldest RX byte on `host_rd_data` one edge after `host_rd_en`, and pops that byte. If the RX FIFO is empty or the RX path is off, the read returns 0x00 and pops nothing.
- R9: A line beat with `line_break` high stores 0x00, whatever the value on `line_data`.
- R10: `line_ready` is 0 whenever a FIFO that the current mode routes line bytes into is full. A line beat offered while `line_ready` is 0 is written to neither FIFO.
- R11: `tx_valid` is 1 while the TX FIFO holds data, and `tx_data` shows the oldest byte. `tx_pop` removes that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr_en | input | 1 | Control word write strobe |
| ctrl_wr_data | input | 9 | Control word write value |
| ctrl_q | output | 9 | Stored control word |
| mode | input | 2 | Channel mode (0 normal, 1 echo, 2 local loopback, 3 remote loopback) |
| host_wr_en | input | 1 | Host data register write strobe |
| host_wr_data | input | 8 | Host byte to write |
| host_rd_en | input | 1 | Host data register read strobe |
| host_rd_data | output | 8 | Byte returned for the previous read |
| line_valid | input | 1 | Line receiver offers a beat |
| line_data | input | 8 | Received byte |
| line_break | input | 1 | The beat is a break condition |
| line_ready | output | 1 | The targeted FIFOs can accept a line beat |
| tx_valid | output | 1 | TX FIFO not empty |
| tx_data | output | 8 | Oldest TX byte |
| tx_pop | input | 1 | Serializer takes the TX head |
| break_req | output | 1 | Break requested on the line |
| rx_overrun_evt | output | 1 | One-cycle pulse: RX byte dropped, FIFO full |
| tx_overflow_evt | output | 1 | One-cycle pulse: TX byte dropped, FIFO full |
| rx_level | output | clog2(RX_DEPTH+1) | RX FIFO occupancy |
| tx_level | output | clog2(TX_DEPTH+1) | TX FIFO occupancy |

## Verification
The hardest case to reach is echo mode with only one of the two FIFOs full. In that case the line beat must be refused as a whole, and only the event of the full side may fire. To get there, the bench first fills the RX FIFO with line bytes in normal mode, then switches to echo with the TX FIFO still empty, and offers a beat anyway. The bench also checks that a read with the RX path disabled leaves a stored byte in place. It does this by re-enabling RX and reading the byte back.

// File: rtl/uart_route_pkg.sv
package uart_route_pkg;

    typedef enum logic [1:0] {
        CH_NORMAL    = 2'd0,
        CH_ECHO      = 2'd1,
        CH_LOCAL_LB  = 2'd2,
        CH_REMOTE_LB = 2'd3
    } chan_mode_e;

    localparam int          CTRL_W     = 9;
    localparam logic [8:0]  CTRL_RESET = 9'h128;

    localparam int B_RX_CLR  = 0;
    localparam int B_TX_CLR  = 1;
    localparam int B_RX_EN   = 2;
    localparam int B_RX_DIS  = 3;
    localparam int B_TX_EN   = 4;
    localparam int B_TX_DIS  = 5;
    localparam int B_BRK_ON  = 7;
    localparam int B_BRK_OFF = 8;

    typedef struct packed {
        logic rx_on;
        logic tx_on;
        logic brk;
    } path_state_t;

    typedef struct packed {
        logic to_rx;
        logic to_tx;
    } route_t;

    function automatic logic pair_on(input logic en, input logic dis);
        return en & ~dis;
    endfunction

    function automatic route_t line_route(input chan_mode_e m);
        route_t r;
        r.to_rx = (m == CH_NORMAL) || (m == CH_ECHO);
        r.to_tx = (m == CH_REMOTE_LB) || (m == CH_ECHO);
        return r;
    endfunction

    function automatic route_t host_route(input chan_mode_e m);
        route_t r;
        r.to_rx = (m == CH_LOCAL_LB);
        r.to_tx = (m == CH_NORMAL);
        return r;
    endfunction

endpackage

// File: rtl/uart_route_ctrl.sv
module uart_route_ctrl
    import uart_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              rx_clr,
    output logic              tx_clr,
    output path_state_t       st
);
    logic [CTRL_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= CTRL_RESET;
            rx_clr <= 1'b0;
            tx_clr <= 1'b0;
        end else begin
            rx_clr <= wr_en & wr_data[B_RX_CLR];
            tx_clr <= wr_en & wr_data[B_TX_CLR];
            if (wr_en) begin
                word_q <= wr_data;
                word_q[B_RX_CLR] <= 1'b0;
                word_q[B_TX_CLR] <= 1'b0;
            end
        end
    end

    assign ctrl_q   = word_q;
    assign st.rx_on = pair_on(word_q[B_RX_EN], word_q[B_RX_DIS]);
    assign st.tx_on = pair_on(word_q[B_TX_EN], word_q[B_TX_DIS]);
    assign st.brk   = pair_on(word_q[B_BRK_ON], word_q[B_BRK_OFF]);
endmodule

// File: rtl/uart_route_fifo.sv
module uart_route_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic                         full,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [LW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == FULL_LVL);
    assign empty   = (cnt == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= push_data;
                wp      <= (wp == LAST) ? '0 : wp + 1'b1;
            end
            if (do_pop)
                rp <= (rp == LAST) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign head  = mem[rp];
    assign level = cnt;
endmodule

// File: rtl/uart_route_steer.sv
module uart_route_steer
    import uart_route_pkg::*;
#(
    parameter int W = 8
) (
    input  chan_mode_e  mode,
    input  path_state_t st,
    input  logic        line_valid,
    input  logic [W-1:0] line_data,
    input  logic        line_break,
    input  logic        host_wr_en,
    input  logic [W-1:0] host_wr_data,
    input  logic        rx_full,
    input  logic        tx_full,
    output logic        line_ready,
    output logic        rx_push,
    output logic [W-1:0] rx_push_data,
    output logic        tx_push,
    output logic [W-1:0] tx_push_data,
    output logic        rx_ovr_hit,
    output logic        tx_ovf_hit
);
    route_t       lr, hr;
    logic [W-1:0] lbyte;
    logic         line_rx, line_tx, host_rx, host_tx;

    always_comb begin
        lr         = line_route(mode);
        hr         = host_route(mode);
        lbyte      = line_break ? '0 : line_data;
        line_ready = ~(lr.to_rx & rx_full) & ~(lr.to_tx & tx_full);

        line_rx = line_valid & lr.to_rx & st.rx_on;
        line_tx = line_valid & lr.to_tx & st.tx_on;
        host_rx = host_wr_en & hr.to_rx & st.rx_on;
        host_tx = host_wr_en & hr.to_tx & st.tx_on;

        rx_push      = (line_rx & line_ready) | (host_rx & ~rx_full);
        rx_push_data = line_rx ? lbyte : host_wr_data;
        tx_push      = (line_tx & line_ready) | (host_tx & ~tx_full);
        tx_push_data = line_tx ? lbyte : host_wr_data;

        rx_ovr_hit = (line_rx | host_rx) & rx_full;
        tx_ovf_hit = (line_tx | host_tx) & tx_full;
    end
endmodule

// File: rtl/uart_route_top.sv
module uart_route_top
    import uart_route_pkg::*;
#(
    parameter int RX_DEPTH = 8,
    parameter int TX_DEPTH = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            ctrl_wr_en,
    input  logic [8:0]                      ctrl_wr_data,
    output logic [8:0]                      ctrl_q,
    input  logic [1:0]                      mode,
    input  logic                            host_wr_en,
    input  logic [7:0]                      host_wr_data,
    input  logic                            host_rd_en,
    output logic [7:0]                      host_rd_data,
    input  logic                            line_valid,
    input  logic [7:0]                      line_data,
    input  logic                            line_break,
    output logic                            line_ready,
    output logic                            tx_valid,
    output logic [7:0]                      tx_data,
    input  logic                            tx_pop,
    output logic                            break_req,
    output logic                            rx_overrun_evt,
    output logic                            tx_overflow_evt,
    output logic [$clog2(RX_DEPTH+1)-1:0]   rx_level,
    output logic [$clog2(TX_DEPTH+1)-1:0]   tx_level
);
    localparam int W = 8;

    path_state_t st;
    logic        rx_clr, tx_clr;
    logic        rx_push, tx_push, rx_full, tx_full, rx_empty, tx_empty;
    logic [W-1:0] rx_push_data, tx_push_data, rx_head;
    logic        rx_ovr_hit, tx_ovf_hit, rx_pop;

    uart_route_ctrl u_ctrl (
        .clk(clk), .rst(rst), .wr_en(ctrl_wr_en), .wr_data(ctrl_wr_data),
        .ctrl_q(ctrl_q), .rx_clr(rx_clr), .tx_clr(tx_clr), .st(st)
    );

    uart_route_steer #(.W(W)) u_steer (
        .mode(chan_mode_e'(mode)), .st(st),
        .line_valid(line_valid), .line_data(line_data), .line_break(line_break),
        .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
        .rx_full(rx_full), .tx_full(tx_full), .line_ready(line_ready),
        .rx_push(rx_push), .rx_push_data(rx_push_data),
        .tx_push(tx_push), .tx_push_data(tx_push_data),
        .rx_ovr_hit(rx_ovr_hit), .tx_ovf_hit(tx_ovf_hit)
    );

    uart_route_fifo #(.DEPTH(RX_DEPTH), .W(W)) u_rx_fifo (
        .clk(clk), .rst(rst), .clr(rx_clr), .push(rx_push),
        .push_data(rx_push_data), .pop(rx_pop), .head(rx_head),
        .full(rx_full), .empty(rx_empty), .level(rx_level)
    );

    uart_route_fifo #(.DEPTH(TX_DEPTH), .W(W)) u_tx_fifo (
        .clk(clk), .rst(rst), .clr(tx_clr), .push(tx_push),
        .push_data(tx_push_data), .pop(tx_pop), .head(tx_data),
        .full(tx_full), .empty(tx_empty), .level(tx_level)
    );

    assign rx_pop    = host_rd_en & st.rx_on & ~rx_empty;
    assign tx_valid  = ~tx_empty;
    assign break_req = st.brk;

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rd_data    <= '0;
            rx_overrun_evt  <= 1'b0;
            tx_overflow_evt <= 1'b0;
        end else begin
            host_rd_data    <= rx_pop ? rx_head : '0;
            rx_overrun_evt  <= rx_ovr_hit;
            tx_overflow_evt <= tx_ovf_hit;
        end
    end
endmodule

// File: rtl/uart_route_chk.sv
module uart_route_chk #(
    parameter int RX_DEPTH = 8,
    parameter int TX_DEPTH = 8
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          ctrl_wr_en,
    input logic [8:0]                    ctrl_wr_data,
    input logic [8:0]                    ctrl_q,
    input logic [1:0]                    mode,
    input logic                          host_rd_en,
    input logic [7:0]                    host_rd_data,
    input logic                          line_valid,
    input logic                          line_ready,
    input logic                          break_req,
    input logic                          rx_overrun_evt,
    input logic [$clog2(RX_DEPTH+1)-1:0] rx_level,
    input logic [$clog2(TX_DEPTH+1)-1:0] tx_level
);
    AST_RESET_WORD: assert property (@(posedge clk) rst |=> (ctrl_q == 9'h128 && rx_level == 0 && tx_level == 0)); // R4
    AST_CLR_BITS_DROP: assert property (@(posedge clk) disable iff (rst) ctrl_wr_en |=> (ctrl_q[1:0] == 2'b00)); // R1
    AST_RX_CLEARED: assert property (@(posedge clk) disable iff (rst) (ctrl_wr_en && ctrl_wr_data[0]) |=> ##1 (rx_level == 0)); // R1
    AST_STOP_BREAK: assert property (@(posedge clk) disable iff (rst) (ctrl_wr_en && ctrl_wr_data[8]) |=> !break_req); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) (rx_level <= RX_DEPTH) && (tx_level <= TX_DEPTH)); // R7
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst) (host_rd_en && rx_level == 0) |=> (host_rd_data == 8'h00)); // R8
    AST_READY_LOW: assert property (@(posedge clk) disable iff (rst) (mode == 2'd0 && rx_level == RX_DEPTH) |-> !line_ready); // R10
    AST_OVERRUN_EVT: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 && ctrl_q[2] && !ctrl_q[3] && line_valid && rx_level == RX_DEPTH) |=> rx_overrun_evt); // R7
endmodule

bind uart_route_top uart_route_chk #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) u_chk (
    .clk(clk), .rst(rst), .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_data(ctrl_wr_data),
    .ctrl_q(ctrl_q), .mode(mode), .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
    .line_valid(line_valid), .line_ready(line_ready), .break_req(break_req),
    .rx_overrun_evt(rx_overrun_evt), .rx_level(rx_level), .tx_level(tx_level)
);

// File: tb/tb_uart_route_top.sv
module tb_uart_route_top;
    localparam int D = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctrl_wr_en = 0;
    logic [8:0] ctrl_wr_data = 0;
    logic [8:0] ctrl_q;
    logic [1:0] mode = 0;
    logic       host_wr_en = 0;
    logic [7:0] host_wr_data = 0;
    logic       host_rd_en = 0;
    logic [7:0] host_rd_data;
    logic       line_valid = 0;
    logic [7:0] line_data = 0;
    logic       line_break = 0;
    logic       line_ready, tx_valid, tx_pop = 0, break_req;
    logic [7:0] tx_data;
    logic       rx_overrun_evt, tx_overflow_evt;
    logic [3:0] rx_level, tx_level;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    uart_route_top #(.RX_DEPTH(D), .TX_DEPTH(D)) dut (.*);

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [8:0] v);
        ctrl_wr_en = 1; ctrl_wr_data = v;
        @(negedge clk);
        ctrl_wr_en = 0;
    endtask

    task automatic host_wr(input logic [7:0] b);
        host_wr_en = 1; host_wr_data = b;
        @(negedge clk);
        host_wr_en = 0;
    endtask

    task automatic host_rd(output logic [7:0] b);
        host_rd_en = 1;
        @(negedge clk);
        host_rd_en = 0;
        b = host_rd_data;
    endtask

    task automatic line_put(input logic [7:0] b, input logic brk);
        line_valid = 1; line_data = b; line_break = brk;
        @(negedge clk);
        line_valid = 0; line_break = 0;
    endtask

    task automatic flush();
        wr_ctrl(9'h117);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R4 ctrl reset", ctrl_q, 9'h128);
        check("R4 rx empty", rx_level, 0);
        check("R4 tx empty", tx_level, 0);
        check("R4 break off", break_req, 0);
        check("R4 ready", line_ready, 1);
        check("R11 tx_valid idle", tx_valid, 0);
    endtask

    task automatic t_normal();
        logic [7:0] b;
        mode = 2'd0;
        wr_ctrl(9'h114);
        host_wr(8'hA1); host_wr(8'hA2); host_wr(8'hA3);
        check("R6 normal host->tx", tx_level, 3);
        check("R11 tx_valid", tx_valid, 1);
        check("R11 tx head", tx_data, 8'hA1);
        line_put(8'h51, 0); line_put(8'h52, 0);
        check("R5 normal line->rx", rx_level, 2);
        check("R6 normal host not rx", rx_level, 2);
        host_rd(b); check("R8 first byte", b, 8'h51);
        host_rd(b); check("R8 second byte", b, 8'h52);
        host_rd(b); check("R8 empty read zero", b, 0);
        check("R8 empty no pop", rx_level, 0);
        tx_pop = 1; @(negedge clk); tx_pop = 0;
        check("R11 pop advances", tx_data, 8'hA2);
        check("R11 pop level", tx_level, 2);
        flush();
        check("R1 tx cleared", tx_level, 0);
        check("R1 clr bits read 0", ctrl_q[1:0], 0);
    endtask

    task automatic t_disable();
        logic [7:0] b;
        mode = 2'd0;
        line_put(8'h77, 0);
        wr_ctrl(9'h11C);
        line_put(8'h78, 0);
        check("R2 rx disabled drops line", rx_level, 1);
        host_rd(b);
        check("R2 read while disabled zero", b, 0);
        check("R8 disabled read no pop", rx_level, 1);
        wr_ctrl(9'h134);
        host_wr(8'h99);
        check("R2 tx disabled drops host", tx_level, 0);
        wr_ctrl(9'h114);
        host_rd(b);
        check("R8 byte kept across disable", b, 8'h77);
        flush();
    endtask

    task automatic t_modes();
        mode = 2'd1;
        line_put(8'h11, 0);
        check("R5 echo rx", rx_level, 1);
        check("R5 echo tx", tx_level, 1);
        host_wr(8'h12);
        check("R6 echo host dropped", tx_level + rx_level, 2);
        flush();
        mode = 2'd2;
        host_wr(8'h21);
        check("R6 local host->rx", rx_level, 1);
        check("R6 local host not tx", tx_level, 0);
        line_put(8'h22, 0);
        check("R5 local line dropped", rx_level + tx_level, 1);
        flush();
        mode = 2'd3;
        line_put(8'h31, 0);
        check("R5 remote line->tx", tx_level, 1);
        check("R5 remote not rx", rx_level, 0);
        check("R5 remote byte", tx_data, 8'h31);
        host_wr(8'h32);
        check("R6 remote host dropped", tx_level, 1);
        flush();
    endtask

    task automatic t_full();
        mode = 2'd0;
        for (int i = 0; i < D; i++) line_put(8'(i), 0);
        check("R10 ready low on full rx", line_ready, 0);
        line_put(8'hEE, 0);
        check("R7 overrun event", rx_overrun_evt, 1);
        check("R7 rx level held", rx_level, D);
        @(negedge clk);
        check("R7 overrun one cycle", rx_overrun_evt, 0);
        mode = 2'd1;
        check("R10 echo ready low", line_ready, 0);
        line_put(8'hEF, 0);
        check("R10 echo tx untouched", tx_level, 0);
        check("R7 echo no tx event", tx_overflow_evt, 0);
        mode = 2'd0;
        for (int i = 0; i < D; i++) host_wr(8'(8'h40 + i));
        host_wr(8'hFF);
        check("R7 tx overflow event", tx_overflow_evt, 1);
        check("R7 tx level held", tx_level, D);
        wr_ctrl(9'h115);
        @(negedge clk);
        check("R1 rx cleared", rx_level, 0);
        check("R1 tx kept", tx_level, D);
        flush();
    endtask

    task automatic t_break();
        logic [7:0] b;
        mode = 2'd0;
        wr_ctrl(9'h094);
        check("R3 break on", break_req, 1);
        wr_ctrl(9'h194);
        check("R3 stop wins", break_req, 0);
        wr_ctrl(9'h114);
        line_put(8'h5A, 1);
        host_rd(b);
        check("R9 break byte zero", b, 0);
        check("R9 break popped", rx_level, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_normal();
        t_disable();
        t_modes();
        t_full();
        t_break();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule